// File: doc/BRIEF.md
# Serial Stereo Audio Receiver with Frame Realignment

This block receives a stereo audio stream on three wires: a bit clock, a word-select clock, and serial data in standard I2S framing. It rebuilds one 24-bit two's-complement sample per channel and presents each left/right pair in the system clock domain, together with a single-cycle valid strobe. All three serial wires are oversampled by the system clock. The block does not need a clock of its own.

The block keeps a free-running count of bit-clock periods across a nominal frame, and each frame start is checked against that count. If a frame start lands more than a set number of bit clocks away from the predicted position, in either direction, the block realigns its count to the observed edge. It then raises a mute flag and publishes zero (bipolar zero) samples. The flag clears at the next frame start that lands where the realigned count predicts, so it covers at least one full frame. A downstream filter or modulator uses the flag to hold its output at midscale.

Top module: `i2s_resync_rx`

## Requirements
- R1: Each sample is 24 bits, two's complement, MSB first. The MSB is the data bit present at the second bit-clock rising edge after a word-select transition, and each following rising edge carries the next lower bit.
- R2: Bits sent while word-select is low form the left sample. Bits sent while it is high form the right sample.
- R3: A pair is published once per frame, at the word-select high-to-low transition. valid_o is high for exactly one system clock. left_o and right_o do not change on any other cycle.
- R4: Data at the 26th and later rising edges of a half-frame (counting the edge at the transition as the 1st) is ignored.
- R5: If a half-frame ends before all 24 bits arrive, the missing low-order bits are zero.
- R6: The data bit at the rising edge where word-select changes still belongs to the half-frame that is ending. With 24-slot half-frames, this bit is that sample's LSB.
- R7: A frame start that lands up to 6 bit clocks early or late relative to the predicted position (frame = 64 bit clocks) causes no realignment and does not raise mute_o.
- R8: A frame start more than 6 bit clocks away from the predicted position realigns the frame count to that edge and sets mute_o. The pair published at that edge is all zeros.
- R9: mute_o clears at the next frame start that lands within the allowed window, and not before.
- R10: During and after reset, left_o and right_o are zero, valid_o is low and mute_o is high. The first frame start after reset always counts as a realignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial bit clock, asynchronous |
| wsel_i | input | 1 | Word select: low = left, high = right |
| sdata_i | input | 1 | Serial audio data |
| left_o | output | 24 | Left sample, two's complement |
| right_o | output | 24 | Right sample, two's complement |
| valid_o | output | 1 | One-cycle strobe when a new pair is presented |
| mute_o | output | 1 | High while the frame is being realigned; samples forced to zero |

## Verification
A bit-clock rising edge at the pins passes two synchronizer flops and is detected in the third system cycle. The pair registers, valid_o and mute_o therefore change 3 system clocks after the pin edge that starts a frame. The bench holds each bit-clock phase for 5 system clocks and checks the pair, the mute flag and the count of valid strobes only after the whole following frame has been sent. The results are then many cycles old and sampled on the falling clock edge. Frame lengths are chosen so that frame starts land exactly 6 and 7 bit clocks early and late, which exercises both sides of the realignment window.

// File: rtl/i2s_resync_rx.sv
module i2s_resync_rx #(
  parameter int WORD_W     = 24,
  parameter int HALF_SLOTS = 32,
  parameter int DRIFT_MAX  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              wsel_i,
  input  logic              sdata_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o,
  output logic              mute_o
);
  localparam int FRAME   = 2 * HALF_SLOTS;
  localparam int POS_W   = $clog2(FRAME);
  localparam int CNT_MAX = WORD_W + 2;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [2:0] sclk_sy;
  logic [1:0] ws_sy, sd_sy;
  logic ws_q, locked;
  logic [CNT_W-1:0] cnt;
  logic [WORD_W-1:0] word, left_hold, word_ins;
  logic [POS_W-1:0] fpos, fpos_n;
  logic [POS_W:0] drift;
  logic [CNT_W:0] slot_n;

  wire bclk_rise = sclk_sy[1] & ~sclk_sy[2];
  wire ws        = ws_sy[1];
  wire sd        = sd_sy[1];
  wire ws_edge   = ws ^ ws_q;
  wire ws_fall   = ws_q & ~ws;

  assign slot_n = {1'b0, cnt} + 1'b1;
  wire take = (slot_n >= (CNT_W+1)'(2)) && (slot_n <= (CNT_W+1)'(WORD_W + 1));

  always_comb begin
    word_ins = word;
    for (int b = 0; b < WORD_W; b++)
      if (take && (32'(slot_n) == 32'(WORD_W + 1 - b))) word_ins[b] = sd;
  end

  assign fpos_n = (fpos == POS_W'(FRAME - 1)) ? '0 : fpos + 1'b1;
  assign drift  = ({1'b0, fpos_n} <= (POS_W+1)'(HALF_SLOTS)) ? {1'b0, fpos_n}
                                                            : (POS_W+1)'(FRAME) - {1'b0, fpos_n};
  wire realign = ws_fall && (!locked || drift > (POS_W+1)'(DRIFT_MAX));
  wire mute_n  = realign ? 1'b1 : (ws_fall ? 1'b0 : mute_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sy   <= '0;
      ws_sy     <= '0;
      sd_sy     <= '0;
      ws_q      <= 1'b0;
      cnt       <= CNT_W'(CNT_MAX);
      word      <= '0;
      left_hold <= '0;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
      mute_o    <= 1'b1;
      fpos      <= '0;
      locked    <= 1'b0;
    end else begin
      sclk_sy <= {sclk_sy[1:0], sclk_i};
      ws_sy   <= {ws_sy[0], wsel_i};
      sd_sy   <= {sd_sy[0], sdata_i};
      valid_o <= 1'b0;
      if (bclk_rise) begin
        ws_q   <= ws;
        fpos   <= realign ? '0 : fpos_n;
        mute_o <= mute_n;
        if (ws_fall) locked <= 1'b1;
        if (ws_edge) begin
          cnt  <= CNT_W'(1);
          word <= '0;
          if (!ws_q) begin
            left_hold <= word_ins;
          end else begin
            valid_o <= 1'b1;
            left_o  <= mute_n ? '0 : left_hold;
            right_o <= mute_n ? '0 : word_ins;
          end
        end else begin
          word <= word_ins;
          if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assert_valid_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  assert_valid_from_bclk_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(bclk_rise));
  assert_hold_between_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));
  assert_muted_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && mute_o) |-> (left_o == '0 && right_o == '0));
  assert_mute_rise_at_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mute_o) |-> valid_o);
  assert_mute_fall_at_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mute_o) |-> valid_o);
endmodule

// File: tb/sim_i2s_resync_rx.sv
module sim_i2s_resync_rx;
  logic clk = 0, rst_n = 0, sclk_i = 0, wsel_i = 1, sdata_i = 0;
  logic [23:0] left_o, right_o;
  logic valid_o, mute_o;
  int checks = 0, fails = 0, vcnt = 0, wide = 0;
  logic [23:0] last_l = 0, last_r = 0;
  logic prev_valid = 0, prev_bit = 0, done = 0;

  always #5 clk = ~clk;

  i2s_resync_rx u0 (.clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .wsel_i(wsel_i),
                    .sdata_i(sdata_i), .left_o(left_o), .right_o(right_o),
                    .valid_o(valid_o), .mute_o(mute_o));

  always @(negedge clk) begin
    if (valid_o) begin
      vcnt++;
      last_l = left_o;
      last_r = right_o;
      if (prev_valid) wide++;
    end
    prev_valid = valid_o;
  end

  typedef struct packed {
    logic [23:0] l, r;
    int hl, hr;
    logic [23:0] el, er;
    logic em;
  } row_t;

  // each row: frame sent (left, right, half lengths); expected pair/mute seen after it,
  // which reflect the frame start that opened this row (closing the previous one)
  localparam row_t ROWS [13] = '{
    '{24'h800000, 24'h7FFFFF, 32, 32, 24'h000000, 24'h000000, 1'b1}, // R10 first start realigns
    '{24'h123456, 24'hABCDEF, 32, 32, 24'h800000, 24'h7FFFFF, 1'b0}, // R9 clears after a frame
    '{24'h000001, 24'hFFFFFE, 32, 38, 24'h123456, 24'hABCDEF, 1'b0}, // R1 R2
    '{24'h5A5A5A, 24'hA5A5A5, 32, 26, 24'h000001, 24'hFFFFFE, 1'b0}, // R7 late by 6, R4 38 slots
    '{24'hC0FFEE, 24'h0F1E2D, 29, 29, 24'h5A5A5A, 24'hA5A5A5, 1'b0},
    '{24'h7F0001, 24'h80FFFF, 32, 38, 24'hC0FFEE, 24'h0F1E2D, 1'b0}, // R7 early by 6
    '{24'h111111, 24'h222222, 35, 36, 24'h7F0001, 24'h80FFFF, 1'b0},
    '{24'hFEDCBA, 24'h013579, 32, 32, 24'h000000, 24'h000000, 1'b1}, // R8 late by 7
    '{24'hABCDEF, 24'h654321, 16, 48, 24'hFEDCBA, 24'h013579, 1'b0}, // R9
    '{24'h3C3C3C, 24'hC3C3C3, 24, 40, 24'hABCD00, 24'h654321, 1'b0}, // R5 R4
    '{24'h999999, 24'h666666, 32, 25, 24'h3C3C3C, 24'hC3C3C3, 1'b0}, // R6 24-slot left
    '{24'hDEAD01, 24'h0BEEF0, 32, 32, 24'h000000, 24'h000000, 1'b1}, // R8 early by 7
    '{24'h000000, 24'h000000, 32, 32, 24'hDEAD01, 24'h0BEEF0, 1'b0}  // R9
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic slot(input logic ws, input logic b);
    sclk_i = 0;
    wsel_i = ws;
    sdata_i = prev_bit;
    prev_bit = b;
    repeat (5) @(negedge clk);
    sclk_i = 1;
    repeat (5) @(negedge clk);
  endtask

  task automatic half(input logic ws, input logic [23:0] w, input int n);
    for (int j = 0; j < n; j++) slot(ws, (j < 24) ? w[23-j] : 1'b1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R3 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(left_o == 0 && right_o == 0, "R10 reset samples", {left_o[15:0], right_o[15:0]}, 0);
    chk(valid_o == 0, "R10 reset valid", valid_o, 0);
    chk(mute_o == 1, "R10 reset mute", mute_o, 1);
    rst_n = 1;
    repeat (4) slot(1'b1, 1'b0);
    chk(vcnt == 0, "R3 no pair before first frame start", vcnt, 0);
    chk(mute_o == 1, "R10 mute held before alignment", mute_o, 1);

    for (int i = 0; i < 13; i++) begin
      int v0;
      v0 = vcnt;
      half(1'b0, ROWS[i].l, ROWS[i].hl);
      half(1'b1, ROWS[i].r, ROWS[i].hr);
      chk(vcnt - v0 == 1, "R3 one pair per frame", vcnt - v0, 1);
      chk(last_l == ROWS[i].el, "R1 R2 R5 R6 left sample", last_l, ROWS[i].el);
      chk(last_r == ROWS[i].er, "R1 R2 R4 R8 right sample", last_r, ROWS[i].er);
      chk(mute_o == ROWS[i].em, "R7 R8 R9 mute flag", mute_o, ROWS[i].em);
    end
    chk(wide == 0, "R3 valid one cycle wide", wide, 0);

    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    chk(left_o == 0 && right_o == 0, "R10 samples cleared by reset", {left_o[15:0], right_o[15:0]}, 0);
    chk(mute_o == 1 && valid_o == 0, "R10 mute set by reset", {mute_o, valid_o}, 2);
    finish_run();
  end
endmodule